// File: doc/BRIEF.md
# Snoop Conflict Resolver

This block sits beside a cache's snoop port and decides, for each incoming bus snoop, whether the cache's in-flight work on the same line must steer the answer. It looks at one pending miss-status register (its line address, whether it is valid and already in service, whether it is an invalidating request and whether it is a line fill) and at a small writeback buffer of line-sized entries. From these it chooses exactly one outcome: drop the snoop, refuse it with a NACK, queue a deferred invalidate on the pending miss, serve it from a writeback entry, or hand it to the ordinary coherence logic.

The decision is made from the inputs sampled on a clock edge where `snp_valid` is high and appears on the outputs in the following cycle. Addresses are compared on whole lines: the byte-offset bits below the line size take no part in a match. When a writeback entry serves the snoop, the block reports which entry, whether a data word is forwarded (a read snoop, with the shared-line indication) and whether the entry must be marked in service (an invalidating snoop).

The controller is a Moore machine with states RS_IDLE, RS_IGNORE, RS_NACK, RS_APPEND, RS_FORWARD and RS_PASS. Each state decodes to one decision output. From any state, a cycle without a snoop leads to RS_IDLE; a snoop leads to the state chosen by priority: uncacheable snoop to RS_IGNORE, in-service line-matching miss to RS_NACK or RS_APPEND, cacheable line-matching writeback entry to RS_FORWARD, anything else to RS_PASS.

Top module: `snoop_conflict_resolver`

## Requirements
- R1: While reset is applied and until the first snoop, every decision output, `fwd_idx`, `fwd_data_shared`, `fwd_mark` and `fwd_word` are zero.
- R2: A snoop with `snp_uncache` high raises only `dec_ignore`, whatever the miss and writeback state.
- R3: A snoop matches the miss register or a writeback entry when the addresses agree above bit log2(LINE_BYTES)-1; differing offset bits do not prevent a match and differing upper bits prevent it.
- R4: With a valid, in-service, line-matching miss that is invalidating (`miss_is_inval`) or is not a fill (`miss_is_fill` low), a snoop whose command is neither 2 (invalidate) nor 3 (write-invalidate) raises `dec_nack`.
- R5: With a valid, in-service, line-matching miss where R4 does not apply, the snoop raises `dec_append_inv` and the writeback buffer is not consulted.
- R6: A miss register that is not valid, or valid but not yet in service, has no effect on the decision.
- R7: Among writeback entries that are valid, cacheable (`wb_uncache` low) and line-matching, the lowest index is chosen and given on `fwd_idx`; uncacheable entries are skipped.
- R8: A read snoop (command 0 read or 1 read-exclusive) served from a writeback entry raises `fwd_data_shared` and drives `fwd_word` with the entry's word selected by the snoop address bits just above the word offset (word k at line bits k*WORD_W upward).
- R9: An invalidating snoop (commands 1 read-exclusive, 2 invalidate, 3 write-invalidate, 4 upgrade) served from a writeback entry raises `fwd_mark`; any other command leaves it low, and `fwd_word` is zero when no data is forwarded.
- R10: A read-exclusive snoop (command 1) served from a writeback entry raises `fwd_data_shared` and `fwd_mark` in the same cycle, with `dec_forward`.
- R11: A cacheable snoop that neither meets an in-service matching miss nor a usable writeback entry raises `dec_pass`.
- R12: Each snoop produces exactly one decision output in the next cycle; a cycle without a snoop is followed by none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | A snoop is presented this cycle |
| snp_cmd | input | 3 | Snoop command: 0 read, 1 read-exclusive, 2 invalidate, 3 write-invalidate, 4 upgrade, 5-7 other |
| snp_uncache | input | 1 | Snoop targets an uncacheable address |
| snp_addr | input | ADDR_W | Snoop byte address |
| miss_valid | input | 1 | Miss-status register holds a request |
| miss_in_service | input | 1 | That request has been issued to the bus |
| miss_is_inval | input | 1 | That request is of invalidating kind |
| miss_is_fill | input | 1 | That request fills a line |
| miss_addr | input | ADDR_W | Address of the pending miss |
| wb_valid | input | WB_ENTRIES | Writeback entry occupied, one bit per entry |
| wb_uncache | input | WB_ENTRIES | Writeback entry is uncacheable |
| wb_addr | input | WB_ENTRIES*ADDR_W | Entry addresses, entry i at bits i*ADDR_W upward |
| wb_data | input | WB_ENTRIES*LINE_BYTES*8 | Entry line data, entry i at bits i*LINE_BYTES*8 upward |
| dec_ignore | output | 1 | Snoop dropped |
| dec_nack | output | 1 | Snoop refused |
| dec_append_inv | output | 1 | Append invalidate to the pending miss |
| dec_forward | output | 1 | Snoop served from a writeback entry |
| dec_pass | output | 1 | Hand snoop to coherence logic |
| fwd_idx | output | max(1,log2 WB_ENTRIES) | Chosen writeback entry |
| fwd_data_shared | output | 1 | Word forwarded, shared line signalled |
| fwd_mark | output | 1 | Mark chosen entry in service |
| fwd_word | output | WORD_BYTES*8 | Forwarded data word |

## Verification
Data forwarding and marking an entry in service both belong to the forward decision and fall in the same cycle when a read-exclusive snoop hits a writeback entry. The bench provokes this with directed read-exclusive snoops on a line held by a non-zero writeback entry, and with random commands over a small pool of lines so the overlap recurs. Each outcome is judged by comparing the full output vector, index, word, shared and mark flags together, against a bench model, so losing either half of the pair or selecting the wrong word is reported.

// File: rtl/snoop_res_pkg.sv
package snoop_res_pkg;

    localparam logic [2:0] CMD_READ      = 3'd0;
    localparam logic [2:0] CMD_READ_EX   = 3'd1;
    localparam logic [2:0] CMD_INVAL     = 3'd2;
    localparam logic [2:0] CMD_WRITE_INV = 3'd3;
    localparam logic [2:0] CMD_UPGRADE   = 3'd4;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_IGNORE,
        RS_NACK,
        RS_APPEND,
        RS_FORWARD,
        RS_PASS
    } res_state_e;

    function automatic logic cmd_reads(input logic [2:0] c);
        return (c == CMD_READ) || (c == CMD_READ_EX);
    endfunction

    function automatic logic cmd_invalidates(input logic [2:0] c);
        return (c == CMD_READ_EX) || (c == CMD_INVAL) ||
               (c == CMD_WRITE_INV) || (c == CMD_UPGRADE);
    endfunction

    // Snoops that may never be refused by an in-service miss.
    function automatic logic cmd_nack_exempt(input logic [2:0] c);
        return (c == CMD_INVAL) || (c == CMD_WRITE_INV);
    endfunction

endpackage

// File: rtl/snr_line_cmp.sv
module snr_line_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_line
);
    assign same_line = (addr_a[ADDR_W-1:OFF_W] == addr_b[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/snr_wb_scan.sv
module snr_wb_scan #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 4,
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ADDR_W-1:0]         probe_addr,
    input  logic [ENTRIES-1:0]        ent_valid,
    input  logic [ENTRIES-1:0]        ent_uncache,
    input  logic [ENTRIES*ADDR_W-1:0] ent_addr,
    output logic                      found,
    output logic [IDX_W-1:0]          found_idx
);
    logic [ENTRIES-1:0] line_eq;
    logic [ENTRIES-1:0] usable;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        snr_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp (
            .addr_a    (probe_addr),
            .addr_b    (ent_addr[g*ADDR_W +: ADDR_W]),
            .same_line (line_eq[g])
        );
        assign usable[g] = ent_valid[g] & ~ent_uncache[g] & line_eq[g];
    end

    // Lowest usable index wins: scan downward so the last write is the lowest.
    always_comb begin
        found     = |usable;
        found_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (usable[i]) begin
                found_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/snr_word_pick.sv
module snr_word_pick #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2,
    parameter int LINE_W  = 128,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 2
) (
    input  logic [ENTRIES*LINE_W-1:0] lines,
    input  logic [IDX_W-1:0]          line_sel,
    input  logic [WSEL_W-1:0]         word_sel,
    output logic [WORD_W-1:0]         word
);
    logic [LINE_W-1:0] line;

    always_comb begin
        line = lines[int'(line_sel)*LINE_W +: LINE_W];
        word = line[int'(word_sel)*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/snoop_conflict_resolver.sv
module snoop_conflict_resolver
    import snoop_res_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4,
    parameter int WB_ENTRIES = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WOFF_W    = $clog2(WORD_BYTES),
    localparam int WSEL_W    = (LINE_BYTES > WORD_BYTES) ? $clog2(LINE_BYTES / WORD_BYTES) : 1,
    localparam int WORD_W    = 8 * WORD_BYTES,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int IDX_W     = (WB_ENTRIES > 1) ? $clog2(WB_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         snp_valid,
    input  logic [2:0]                   snp_cmd,
    input  logic                         snp_uncache,
    input  logic [ADDR_W-1:0]            snp_addr,
    input  logic                         miss_valid,
    input  logic                         miss_in_service,
    input  logic                         miss_is_inval,
    input  logic                         miss_is_fill,
    input  logic [ADDR_W-1:0]            miss_addr,
    input  logic [WB_ENTRIES-1:0]        wb_valid,
    input  logic [WB_ENTRIES-1:0]        wb_uncache,
    input  logic [WB_ENTRIES*ADDR_W-1:0] wb_addr,
    input  logic [WB_ENTRIES*LINE_W-1:0] wb_data,
    output logic                         dec_ignore,
    output logic                         dec_nack,
    output logic                         dec_append_inv,
    output logic                         dec_forward,
    output logic                         dec_pass,
    output logic [IDX_W-1:0]             fwd_idx,
    output logic                         fwd_data_shared,
    output logic                         fwd_mark,
    output logic [WORD_W-1:0]            fwd_word
);
    res_state_e state_q, state_d;

    logic              miss_line_eq;
    logic              miss_live;
    logic              nack_cond;
    logic              wb_found;
    logic [IDX_W-1:0]  wb_idx;
    logic [WSEL_W-1:0] word_sel;
    logic [WORD_W-1:0] picked_word;

    logic [IDX_W-1:0]  idx_d, idx_q;
    logic              shared_d, shared_q;
    logic              mark_d, mark_q;
    logic [WORD_W-1:0] word_d, word_q;

    snr_line_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_miss_cmp (
        .addr_a    (snp_addr),
        .addr_b    (miss_addr),
        .same_line (miss_line_eq)
    );

    snr_wb_scan #(
        .ADDR_W (ADDR_W), .OFF_W(OFF_W), .ENTRIES(WB_ENTRIES), .IDX_W(IDX_W)
    ) u_scan (
        .probe_addr  (snp_addr),
        .ent_valid   (wb_valid),
        .ent_uncache (wb_uncache),
        .ent_addr    (wb_addr),
        .found       (wb_found),
        .found_idx   (wb_idx)
    );

    generate
        if (LINE_BYTES > WORD_BYTES) begin : g_wsel
            assign word_sel = snp_addr[WOFF_W +: WSEL_W];
        end else begin : g_wsel_one
            assign word_sel = '0;
        end
    endgenerate

    snr_word_pick #(
        .ENTRIES(WB_ENTRIES), .IDX_W(IDX_W), .LINE_W(LINE_W),
        .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) u_pick (
        .lines    (wb_data),
        .line_sel (wb_idx),
        .word_sel (word_sel),
        .word     (picked_word)
    );

    assign miss_live = miss_valid & miss_in_service & miss_line_eq;
    assign nack_cond = (miss_is_inval | ~miss_is_fill) & ~cmd_nack_exempt(snp_cmd);

    // Next-state selection by fixed priority.
    always_comb begin
        state_d  = RS_IDLE;
        idx_d    = '0;
        shared_d = 1'b0;
        mark_d   = 1'b0;
        word_d   = '0;
        if (snp_valid) begin
            if (snp_uncache) begin
                state_d = RS_IGNORE;
            end else if (miss_live) begin
                state_d = nack_cond ? RS_NACK : RS_APPEND;
            end else if (wb_found) begin
                state_d  = RS_FORWARD;
                idx_d    = wb_idx;
                shared_d = cmd_reads(snp_cmd);
                mark_d   = cmd_invalidates(snp_cmd);
                word_d   = cmd_reads(snp_cmd) ? picked_word : '0;
            end else begin
                state_d = RS_PASS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            idx_q    <= '0;
            shared_q <= 1'b0;
            mark_q   <= 1'b0;
            word_q   <= '0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            shared_q <= shared_d;
            mark_q   <= mark_d;
            word_q   <= word_d;
        end
    end

    // Moore output decode.
    always_comb begin
        dec_ignore      = 1'b0;
        dec_nack        = 1'b0;
        dec_append_inv  = 1'b0;
        dec_forward     = 1'b0;
        dec_pass        = 1'b0;
        fwd_idx         = '0;
        fwd_data_shared = 1'b0;
        fwd_mark        = 1'b0;
        fwd_word        = '0;
        unique case (state_q)
            RS_IDLE:    ;
            RS_IGNORE:  dec_ignore     = 1'b1;
            RS_NACK:    dec_nack       = 1'b1;
            RS_APPEND:  dec_append_inv = 1'b1;
            RS_FORWARD: begin
                dec_forward     = 1'b1;
                fwd_idx         = idx_q;
                fwd_data_shared = shared_q;
                fwd_mark        = mark_q;
                fwd_word        = word_q;
            end
            RS_PASS:    dec_pass = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/snr_checker.sv
module snr_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_valid,
    input logic [2:0]        snp_cmd,
    input logic              snp_uncache,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              miss_valid,
    input logic              miss_in_service,
    input logic              miss_is_inval,
    input logic              miss_is_fill,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              dec_ignore,
    input logic              dec_nack,
    input logic              dec_append_inv,
    input logic              dec_forward,
    input logic              dec_pass,
    input logic              fwd_data_shared,
    input logic              fwd_mark
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [4:0] decs;
    logic       miss_hit;
    logic       exempt;

    assign decs     = {dec_ignore, dec_nack, dec_append_inv, dec_forward, dec_pass};
    assign miss_hit = miss_valid && miss_in_service &&
                      (snp_addr[ADDR_W-1:OFF_W] == miss_addr[ADDR_W-1:OFF_W]);
    assign exempt   = (snp_cmd == 3'd2) || (snp_cmd == 3'd3);

    assert_one_decision_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> ($countones(decs) == 1));

    assert_quiet_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> (decs == 5'd0));

    assert_uncache_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_uncache) |=> dec_ignore);

    assert_nack_on_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_uncache && miss_hit && (miss_is_inval || !miss_is_fill) && !exempt)
        |=> dec_nack);

    assert_append_otherwise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_uncache && miss_hit && !((miss_is_inval || !miss_is_fill) && !exempt))
        |=> dec_append_inv);

    assert_shared_with_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_data_shared |-> dec_forward);

    assert_mark_with_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_mark |-> dec_forward);
endmodule

bind snoop_conflict_resolver snr_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (.*);

// File: tb/sim_snoop_conflict_resolver.sv
module sim_snoop_conflict_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NE = 4;
    localparam int LW = 128;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           snp_valid = 1'b0;
    logic [2:0]     snp_cmd = '0;
    logic           snp_uncache = 1'b0;
    logic [AW-1:0]  snp_addr = '0;
    logic           miss_valid = 1'b0, miss_in_service = 1'b0;
    logic           miss_is_inval = 1'b0, miss_is_fill = 1'b0;
    logic [AW-1:0]  miss_addr = '0;
    logic [NE-1:0]  wb_valid = '0, wb_uncache = '0;
    logic [NE*AW-1:0] wb_addr = '0;
    logic [NE*LW-1:0] wb_data = '0;

    logic dec_ignore, dec_nack, dec_append_inv, dec_forward, dec_pass;
    logic [1:0]  fwd_idx;
    logic        fwd_data_shared, fwd_mark;
    logic [31:0] fwd_word;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_conflict_resolver u0 (.*);

    function automatic logic [40:0] observed();
        return {dec_ignore, dec_nack, dec_append_inv, dec_forward, dec_pass,
                fwd_idx, fwd_data_shared, fwd_mark, fwd_word};
    endfunction

    function automatic logic same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (a >> 4) == (b >> 4);
    endfunction

    // Bit layout: 40 ignore, 39 nack, 38 append, 37 forward, 36 pass,
    // 35:34 index, 33 shared, 32 mark, 31:0 word.
    function automatic logic [40:0] model();
        logic [40:0] e = '0;
        bit rd, inv;
        if (!snp_valid) return e;
        if (snp_uncache) begin
            e[40] = 1'b1;
            return e;
        end
        if (miss_valid && miss_in_service && same_line(snp_addr, miss_addr)) begin
            if ((miss_is_inval || !miss_is_fill) && !(snp_cmd == 3'd2 || snp_cmd == 3'd3))
                e[39] = 1'b1;
            else
                e[38] = 1'b1;
            return e;
        end
        for (int i = 0; i < NE; i++) begin
            if (wb_valid[i] && !wb_uncache[i] && same_line(snp_addr, wb_addr[i*AW +: AW])) begin
                rd  = (snp_cmd == 3'd0) || (snp_cmd == 3'd1);
                inv = (snp_cmd >= 3'd1) && (snp_cmd <= 3'd4);
                e[37]    = 1'b1;
                e[35:34] = 2'(i);
                e[33]    = rd;
                e[32]    = inv;
                if (rd) e[31:0] = wb_data[i*LW + int'(snp_addr[3:2])*32 +: 32];
                return e;
            end
        end
        e[36] = 1'b1;
        return e;
    endfunction

    function automatic string tag_of(input logic [40:0] e);
        if (e[40]) return "R2";
        if (e[39]) return "R4";
        if (e[38]) return "R5";
        if (e[37] && e[33] && e[32]) return "R10";
        if (e[37] && e[33]) return "R8";
        if (e[37]) return "R9";
        if (e[36]) return "R11";
        return "R12";
    endfunction

    task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one snoop (or an idle cycle) and check the next-cycle outputs.
    task automatic step(input bit v, input string req);
        logic [40:0] exp;
        snp_valid = v;
        exp = model();
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        check((req == "") ? tag_of(exp) : req, observed(), exp);
    endtask

    task automatic clear_state();
        miss_valid = 0; miss_in_service = 0; miss_is_inval = 0; miss_is_fill = 0;
        wb_valid = '0; wb_uncache = '0; snp_uncache = 0;
    endtask

    task automatic set_wb(input int i, input logic [AW-1:0] a, input bit unc);
        wb_valid[i]   = 1'b1;
        wb_uncache[i] = unc;
        wb_addr[i*AW +: AW] = a;
        for (int k = 0; k < 4; k++) wb_data[i*LW + k*32 +: 32] = $urandom;
    endtask

    initial begin : watchdog
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R12 actual=hang expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] pool [4];
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1", observed(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observed(), '0);

        // R2: uncacheable beats a refusing miss.
        clear_state();
        miss_valid = 1; miss_in_service = 1; miss_is_inval = 1; miss_addr = 32'h1000;
        snp_addr = 32'h1004; snp_cmd = 3'd0; snp_uncache = 1;
        step(1, "R2");
        snp_uncache = 0;

        // R3/R5: fill miss, offset differs only -> append.
        miss_is_inval = 0; miss_is_fill = 1;
        snp_addr = 32'h100C; snp_cmd = 3'd0;
        step(1, "R3");
        // R3: different line -> pass.
        snp_addr = 32'h1010;
        step(1, "R3");
        // R4: invalidating miss, read snoop -> nack; exempt commands append.
        miss_is_inval = 1; snp_addr = 32'h1008;
        step(1, "R4");
        snp_cmd = 3'd3;
        step(1, "R4");
        snp_cmd = 3'd2;
        step(1, "R5");
        // R4: non-fill miss with upgrade -> nack.
        miss_is_inval = 0; miss_is_fill = 0; snp_cmd = 3'd4;
        step(1, "R4");
        // R5: append even with a matching writeback entry present.
        miss_is_fill = 1; snp_cmd = 3'd0;
        set_wb(0, 32'h1000, 0);
        step(1, "R5");

        // R6: miss not in service -> writeback entry serves.
        miss_in_service = 0;
        step(1, "R6");
        miss_valid = 0; miss_in_service = 1;
        step(1, "R6");

        // R7/R8: lowest cacheable match; uncacheable index 0 skipped.
        clear_state();
        set_wb(0, 32'h2000, 1);
        set_wb(1, 32'h2008, 0);
        set_wb(2, 32'h2000, 0);
        set_wb(3, 32'h3000, 0);
        snp_addr = 32'h200C; snp_cmd = 3'd0;
        step(1, "R7");
        snp_addr = 32'h2004;
        step(1, "R8");
        // R9: invalidate marks only; other command neither.
        snp_cmd = 3'd2;
        step(1, "R9");
        snp_cmd = 3'd6;
        step(1, "R9");
        // R10: read-exclusive does both.
        snp_cmd = 3'd1; snp_addr = 32'h3008;
        step(1, "R10");
        // R11: no match anywhere.
        snp_addr = 32'h4000; snp_cmd = 3'd0;
        step(1, "R11");
        // R12: idle cycle gives nothing.
        step(0, "R12");

        // Random mix over a small pool of lines.
        for (int p = 0; p < 4; p++) pool[p] = 32'h8000 + 32'(p) * 32'h40;
        for (int n = 0; n < 800; n++) begin
            clear_state();
            miss_valid      = ($urandom % 2) == 0;
            miss_in_service = ($urandom % 3) != 0;
            miss_is_inval   = ($urandom % 2) == 0;
            miss_is_fill    = ($urandom % 3) != 0;
            miss_addr       = pool[$urandom % 4] | ($urandom % 16);
            for (int i = 0; i < NE; i++) begin
                if (($urandom % 2) == 0)
                    set_wb(i, pool[$urandom % 4] | ($urandom % 16), ($urandom % 4) == 0);
            end
            snp_cmd     = 3'($urandom % 8);
            snp_uncache = ($urandom % 10) == 0;
            snp_addr    = pool[$urandom % 4] | ($urandom % 16);
            step(($urandom % 8) != 0, "");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule